// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block converts one floating-point operand to a signed two's-complement integer per request. A single datapath serves half, single and double precision, selected by a 2-bit format code. The result is either 32 or 64 bits wide. Rounding is always to nearest, with exact halfway values going to the even neighbour. The integer has no fraction bits.

The operand arrives right-aligned on a 64-bit bus with a one-cycle request strobe. The result, the undefined-encoding indication and any trap request appear one clock later. Invalid-operation and inexact conditions either set sticky status flags or, when the trap-enable input is high, pulse a synchronous trap request and leave the flags alone. The sticky flags are cleared by a clear pulse.

Top module: `fp2int_rne`

## Requirements
- R1: Format code 2'b00 reads a single-precision operand from bits 31:0. Code 2'b01 reads a double-precision operand from bits 63:0. Code 2'b11 reads a half-precision operand from bits 15:0, and only while `half_en` is high.
- R2: Format code 2'b10, or code 2'b11 while `half_en` is low, raises `undef_enc` for one cycle. In that cycle `res_valid` and `trap_req` stay low, `res_int` keeps its previous value, and the flags are not changed.
- R3: The exact value is rounded to the nearest integer. A value exactly halfway between two integers goes to the even one.
- R4: With `wide_sel` = 1 the result is a 64-bit signed integer. With `wide_sel` = 0 it is a 32-bit signed integer, zero-extended into bits 63:32 of `res_int`.
- R5: A NaN operand gives a result of 0 and raises invalid-operation.
- R6: An infinity, or a rounded value outside the signed range of the selected width, raises invalid-operation. The result saturates to the most positive or most negative integer of that width, according to the sign, and inexact is not raised.
- R7: Inexact is raised when the rounded result differs from the operand and invalid-operation is not raised. Zero, subnormal operands and magnitudes below one half give 0.
- R8: With `trap_en` low, the conditions set the sticky flags `flag_invalid` and `flag_inexact`, which stay set until `flag_clr` is pulsed. A condition arriving in the same cycle as `flag_clr` leaves its flag set.
- R9: With `trap_en` high, any condition pulses `trap_req` for one cycle and leaves both flags unchanged.
- R10: A legal request produces `res_valid` and the new `res_int` exactly one cycle after `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Conversion request strobe |
| op_bits | input | 64 | Raw operand, right-aligned |
| fmt_sel | input | 2 | Format code: 00 single, 01 double, 11 half, 10 reserved |
| wide_sel | input | 1 | 0: 32-bit result, 1: 64-bit result |
| half_en | input | 1 | Permits the half-precision format |
| trap_en | input | 1 | 1: request a trap instead of setting flags |
| flag_clr | input | 1 | Clears the sticky flags |
| res_valid | output | 1 | Result valid, one cycle after a legal request |
| res_int | output | 64 | Integer result |
| undef_enc | output | 1 | Reserved or disabled format was requested |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_inexact | output | 1 | Sticky inexact flag |
| trap_req | output | 1 | One-cycle synchronous trap request |

## Verification
A flag clear and a new exception can land in the same cycle. The bench provokes this by pulsing `flag_clr` together with a NaN request while the inexact flag is already set. The expected outcome is that `flag_invalid` ends up set and `flag_inexact` ends up cleared. Around this directed case, random operands in all three formats and both widths are mixed with trap-enabled requests and occasional clears, so that sticky accumulation meets clears and traps at varied points.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;
    localparam int OPW   = 64;
    localparam int MANTW = 53;
    localparam int EXPW  = 13;
    localparam int RESW  = 64;
    localparam int NARW  = 32;

    typedef struct packed {
        logic                   sign;
        logic                   is_nan;
        logic                   is_inf;
        logic signed [EXPW-1:0] exp;
        logic [MANTW-1:0]       mant;
    } fp_unp_t;

    typedef struct packed {
        logic            vld;
        logic [RESW-1:0] res;
        logic            und;
        logic            inv;
        logic            inx;
        logic            trp;
    } cvt_st_t;
endpackage

// File: rtl/fp2i_unpack.sv
module fp2i_unpack
    import fp2i_pkg::*;
(
    input  logic [OPW-1:0] op_bits,
    input  logic [1:0]     fmt_sel,
    output fp_unp_t        unp
);
    logic        sgn;
    logic [10:0] ef;
    logic [51:0] fr;
    logic [10:0] bias;
    logic [10:0] emax;
    logic [10:0] ef_adj;

    always_comb begin
        case (fmt_sel)
            2'b01: begin
                sgn  = op_bits[63];
                ef   = op_bits[62:52];
                fr   = op_bits[51:0];
                bias = 11'd1023;
                emax = 11'h7ff;
            end
            2'b11: begin
                sgn  = op_bits[15];
                ef   = {6'b0, op_bits[14:10]};
                fr   = {op_bits[9:0], 42'b0};
                bias = 11'd15;
                emax = 11'd31;
            end
            default: begin
                sgn  = op_bits[31];
                ef   = {3'b0, op_bits[30:23]};
                fr   = {op_bits[22:0], 29'b0};
                bias = 11'd127;
                emax = 11'd255;
            end
        endcase
        ef_adj     = (ef == 11'd0) ? 11'd1 : ef;
        unp.sign   = sgn;
        unp.is_inf = (ef == emax) && (fr == 52'b0);
        unp.is_nan = (ef == emax) && (fr != 52'b0);
        unp.mant   = {(ef != 11'd0), fr};
        unp.exp    = $signed({2'b00, ef_adj}) - $signed({2'b00, bias});
    end
endmodule

// File: rtl/fp2i_round.sv
module fp2i_round
    import fp2i_pkg::*;
(
    input  fp_unp_t         unp,
    input  logic            wide_sel,
    output logic [RESW-1:0] res,
    output logic            inv,
    output logic            inx
);
    logic signed [EXPW-1:0] e;
    logic signed [EXPW-1:0] lsh;
    logic signed [EXPW-1:0] rsh;
    logic [2*MANTW:0]       shf;
    logic [RESW:0]          mag;
    logic [RESW:0]          mag_r;
    logic [RESW:0]          lim;
    logic                   grd;
    logic                   stk;
    logic                   big;
    logic                   oor;
    logic [RESW-1:0]        sv;
    logic [RESW-1:0]        sat;

    always_comb begin
        e   = unp.exp;
        lsh = e - 13'sd52;
        rsh = 13'sd52 - e;
        grd = 1'b0;
        stk = 1'b0;
        big = 1'b0;
        mag = '0;
        shf = '0;
        if (e > 13'sd63) begin
            big = 1'b1;
        end else if (e > 13'sd52) begin
            mag = {12'b0, unp.mant} << lsh[3:0];
        end else if (e >= -13'sd1) begin
            shf = {unp.mant, 54'b0} >> rsh[5:0];
            mag = {12'b0, shf[106:54]};
            grd = shf[53];
            stk = |shf[52:0];
        end else begin
            stk = |unp.mant;
        end
        mag_r = mag + {64'b0, grd & (stk | mag[0])};
        lim   = wide_sel ? {1'b0, 1'b1, 63'b0} : {33'b0, 1'b1, 31'b0};
        oor   = big || (unp.sign ? (mag_r > lim) : (mag_r >= lim));
        inv   = unp.is_nan || unp.is_inf || oor;
        inx   = !inv && (grd || stk);
        sv    = unp.sign ? (~mag_r[63:0] + 64'd1) : mag_r[63:0];
        if (unp.is_nan)
            sat = '0;
        else if (unp.sign)
            sat = wide_sel ? {1'b1, 63'b0} : {32'b0, 1'b1, 31'b0};
        else
            sat = wide_sel ? {1'b0, {63{1'b1}}} : {33'b0, {31{1'b1}}};
        if (inv)
            res = sat;
        else
            res = wide_sel ? sv : {32'b0, sv[NARW-1:0]};
    end
endmodule

// File: rtl/fp2int_rne.sv
module fp2int_rne
    import fp2i_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OPW-1:0]  op_bits,
    input  logic [1:0]      fmt_sel,
    input  logic            wide_sel,
    input  logic            half_en,
    input  logic            trap_en,
    input  logic            flag_clr,
    output logic            res_valid,
    output logic [RESW-1:0] res_int,
    output logic            undef_enc,
    output logic            flag_invalid,
    output logic            flag_inexact,
    output logic            trap_req
);
    fp_unp_t         unp;
    logic [RESW-1:0] cv_res;
    logic            cv_inv;
    logic            cv_inx;
    logic            bad_fmt;
    cvt_st_t         st_d;
    cvt_st_t         st_q;

    fp2i_unpack u_unpack (
        .op_bits (op_bits),
        .fmt_sel (fmt_sel),
        .unp     (unp)
    );

    fp2i_round u_round (
        .unp      (unp),
        .wide_sel (wide_sel),
        .res      (cv_res),
        .inv      (cv_inv),
        .inx      (cv_inx)
    );

    always_comb begin
        bad_fmt  = (fmt_sel == 2'b10) || ((fmt_sel == 2'b11) && !half_en);
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.und = 1'b0;
        st_d.trp = 1'b0;
        if (flag_clr) begin
            st_d.inv = 1'b0;
            st_d.inx = 1'b0;
        end
        if (op_valid) begin
            if (bad_fmt) begin
                st_d.und = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.res = cv_res;
                if (trap_en) begin
                    st_d.trp = cv_inv || cv_inx;
                end else begin
                    st_d.inv = st_d.inv || cv_inv;
                    st_d.inx = st_d.inx || cv_inx;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign res_valid    = st_q.vld;
    assign res_int      = st_q.res;
    assign undef_enc    = st_q.und;
    assign flag_invalid = st_q.inv;
    assign flag_inexact = st_q.inx;
    assign trap_req     = st_q.trp;

    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        undef_enc |-> (res_int == $past(res_int))); // R2
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        undef_enc |-> (!res_valid && !trap_req)); // R2
    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(wide_sel)) |-> (res_int[63:32] == 32'b0)); // R4
    AST_STICKY_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_invalid && !flag_clr) |=> flag_invalid); // R8
    AST_STICKY_INX: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_inexact && !flag_clr) |=> flag_inexact); // R8
    AST_TRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && trap_en)); // R9
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid)); // R10
endmodule

// File: tb/fp2int_rne_tb.sv
module fp2int_rne_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_bits = '0;
    logic [1:0]  fmt_sel = '0;
    logic        wide_sel = 1'b0;
    logic        half_en = 1'b1;
    logic        trap_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        res_valid;
    logic [63:0] res_int;
    logic        undef_enc;
    logic        flag_invalid;
    logic        flag_inexact;
    logic        trap_req;

    int total = 0;
    int bad = 0;

    logic [63:0] e_res = '0;
    logic        e_inv = 1'b0;
    logic        e_inx = 1'b0;

    always #10 clk = ~clk;

    fp2int_rne u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_bits(op_bits),
        .fmt_sel(fmt_sel), .wide_sel(wide_sel), .half_en(half_en),
        .trap_en(trap_en), .flag_clr(flag_clr), .res_valid(res_valid),
        .res_int(res_int), .undef_enc(undef_enc), .flag_invalid(flag_invalid),
        .flag_inexact(flag_inexact), .trap_req(trap_req)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic ref_conv(input logic [63:0] b, input logic [1:0] f, input logic w,
                            output logic [63:0] r, output logic inv, output logic inx);
        logic sg, nan, inf;
        real m, fl, d, rr, lim, hi, lo;
        logic [63:0] u, sv;
        int ef;
        longint fr;
        inv = 1'b0; inx = 1'b0; r = '0;
        if (f == 2'b01) begin
            sg = b[63]; ef = int'(b[62:52]); fr = longint'(b[51:0]);
            nan = (ef == 2047) && (fr != 0); inf = (ef == 2047) && (fr == 0);
            m = $bitstoreal({1'b0, b[62:0]});
        end else if (f == 2'b11) begin
            sg = b[15]; ef = int'(b[14:10]); fr = longint'(b[9:0]);
            nan = (ef == 31) && (fr != 0); inf = (ef == 31) && (fr == 0);
            if (ef == 0) m = real'(fr) * (2.0 ** (-24));
            else m = real'(fr + 1024) * (2.0 ** (ef - 25));
        end else begin
            sg = b[31]; ef = int'(b[30:23]); fr = longint'(b[22:0]);
            nan = (ef == 255) && (fr != 0); inf = (ef == 255) && (fr == 0);
            if (ef == 0) m = real'(fr) * (2.0 ** (-149));
            else m = real'(fr + 64'd8388608) * (2.0 ** (ef - 150));
        end
        if (nan) begin
            inv = 1'b1; r = '0;
            return;
        end
        lim = w ? 2.0 ** 63 : 2.0 ** 31;
        rr = 0.0; d = 0.0;
        if (!inf) begin
            fl = $floor(m);
            d  = m - fl;
            if (d > 0.5) rr = fl + 1.0;
            else if (d < 0.5) rr = fl;
            else rr = ((fl - 2.0 * $floor(fl / 2.0)) == 0.0) ? fl : fl + 1.0;
        end
        if (inf || (sg ? (rr > lim) : (rr >= lim))) begin
            inv = 1'b1;
            if (sg) r = w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
            else    r = w ? 64'h7fff_ffff_ffff_ffff : 64'h0000_0000_7fff_ffff;
            return;
        end
        hi = $floor(rr / (2.0 ** 32));
        lo = rr - hi * (2.0 ** 32);
        u  = {32'(longint'(hi)), 32'(longint'(lo))};
        sv = sg ? (~u + 64'd1) : u;
        r  = w ? sv : {32'b0, sv[31:0]};
        inx = (d != 0.0);
    endtask

    task automatic run_op(input logic [63:0] b, input logic [1:0] f, input logic w,
                          input logic te, input logic clr, input string tag);
        logic [63:0] r;
        logic inv, inx, legal, e_trp;
        legal = !((f == 2'b10) || ((f == 2'b11) && !half_en));
        @(negedge clk);
        op_valid = 1'b1; op_bits = b; fmt_sel = f; wide_sel = w;
        trap_en = te; flag_clr = clr;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; flag_clr = 1'b0;
        if (clr) begin e_inv = 1'b0; e_inx = 1'b0; end
        e_trp = 1'b0;
        if (legal) begin
            ref_conv(b, f, w, r, inv, inx);
            e_res = r;
            if (te) e_trp = inv | inx;
            else begin e_inv = e_inv | inv; e_inx = e_inx | inx; end
        end
        chk(res_valid == legal, tag, "res_valid", 64'(res_valid), 64'(legal));
        chk(undef_enc == !legal, tag, "undef_enc", 64'(undef_enc), 64'(!legal));
        chk(res_int == e_res, tag, "res_int", res_int, e_res);
        chk(flag_invalid == e_inv, tag, "flag_invalid", 64'(flag_invalid), 64'(e_inv));
        chk(flag_inexact == e_inx, tag, "flag_inexact", 64'(flag_inexact), 64'(e_inx));
        chk(trap_req == e_trp, tag, "trap_req", 64'(trap_req), 64'(e_trp));
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        e_inv = 1'b0; e_inx = 1'b0;
        chk(!flag_invalid && !flag_inexact, "R8", "flags after clear",
            {62'b0, flag_invalid, flag_inexact}, 64'b0);
    endtask

    function automatic logic [63:0] rnd_operand(input logic [1:0] f);
        logic [63:0] v;
        int pick;
        v = {$urandom, $urandom};
        pick = int'($urandom % 8);
        if (f == 2'b01) begin
            v[62:52] = (pick == 0) ? 11'h7ff : (pick == 1) ? 11'd0
                     : 11'(1020 + ($urandom % 70));
            if (pick == 2) v[40:0] = '0;
        end else if (f == 2'b11) begin
            v[63:16] = '0;
            v[14:10] = 5'($urandom % 32);
            if (pick == 2) v[4:0] = '0;
        end else begin
            v[63:32] = '0;
            v[30:23] = (pick == 0) ? 8'hff : (pick == 1) ? 8'd0
                     : 8'(124 + ($urandom % 36));
            if (pick == 2) v[15:0] = '0;
        end
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!res_valid && !undef_enc && !trap_req && !flag_invalid && !flag_inexact
            && res_int == 64'b0, "R10", "reset state", res_int, 64'b0);
        rst_n = 1'b1;

        // R3 ties to even, R1 single and half formats, R4 narrow zero-extension
        run_op(64'h4020_0000, 2'b00, 1'b0, 1'b0, 1'b0, "R3");
        run_op(64'h4060_0000, 2'b00, 1'b0, 1'b0, 1'b0, "R3");
        run_op(64'hC020_0000, 2'b00, 1'b0, 1'b0, 1'b0, "R4");
        run_op(64'h4100, 2'b11, 1'b1, 1'b0, 1'b0, "R1");
        run_op(64'h3FF8_0000_0000_0000, 2'b01, 1'b1, 1'b0, 1'b0, "R1");
        // R7 small values and subnormals
        run_op(64'h3FE0_0000_0000_0000, 2'b01, 1'b1, 1'b0, 1'b1, "R7");
        run_op(64'h0000_0000_0000_0001, 2'b01, 1'b1, 1'b0, 1'b1, "R7");
        run_op(64'h0, 2'b00, 1'b0, 1'b0, 1'b1, "R7");
        // R5 NaN, R6 infinity and range limits
        run_op(64'h7FF8_0000_0000_0000, 2'b01, 1'b1, 1'b0, 1'b1, "R5");
        run_op(64'h7F80_0000, 2'b00, 1'b0, 1'b0, 1'b1, "R6");
        run_op(64'h4F00_0000, 2'b00, 1'b0, 1'b0, 1'b1, "R6");
        run_op(64'h4F00_0000, 2'b00, 1'b1, 1'b0, 1'b1, "R4");
        run_op(64'hCF00_0000, 2'b00, 1'b0, 1'b0, 1'b1, "R6");
        run_op(64'hC3E0_0000_0000_0000, 2'b01, 1'b1, 1'b0, 1'b1, "R6");
        run_op(64'h43E0_0000_0000_0000, 2'b01, 1'b1, 1'b0, 1'b1, "R6");
        run_op(64'hFC00, 2'b11, 1'b1, 1'b0, 1'b1, "R6");
        // R2 reserved and disabled formats
        run_op(64'h4020_0000, 2'b10, 1'b0, 1'b0, 1'b0, "R2");
        half_en = 1'b0;
        run_op(64'h7E00, 2'b11, 1'b0, 1'b0, 1'b0, "R2");
        half_en = 1'b1;
        // R9 trap instead of flags
        clear_flags();
        run_op(64'h4020_0000, 2'b00, 1'b0, 1'b1, 1'b0, "R9");
        run_op(64'h7FF8_0000_0000_0000, 2'b01, 1'b1, 1'b1, 1'b0, "R9");
        // R8 clear and exception in the same cycle
        run_op(64'h4020_0000, 2'b00, 1'b0, 1'b0, 1'b0, "R8");
        run_op(64'h7FC0_0000, 2'b00, 1'b0, 1'b0, 1'b1, "R8");

        for (int i = 0; i < 600; i++) begin
            logic [1:0] f;
            int k;
            k = int'($urandom % 3);
            f = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
            run_op(rnd_operand(f), f, 1'($urandom), ($urandom % 6) == 0,
                   ($urandom % 10) == 0, "R3");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule